// File: doc/BRIEF.md
# Word-Wide Burst Port over a Byte Buffer

This block lets a 16-bit host bus stream data into and out of a small internal buffer that is stored as bytes. Software first programs a length in bytes and then issues one command code that opens a burst in either direction. After that, each access to the data port moves one 16-bit word. The byte at the even buffer address travels in the upper half of the word, and the byte at the next odd address travels in the lower half. An internal byte pointer steps by two after each word.

When the pointer reaches or passes the programmed length, the burst closes. An end-of-transfer pulse then sets a sticky interrupt bit and raises a buffer-done flag. Accesses that arrive after the close, accesses in the wrong direction, and unknown command codes leave both the pointer and the buffer unchanged.

The host bus has four registers, chosen by `busSel`. Select 0 is the command register, 1 is the data port, 2 is the byte count, and 3 is status. Read data is registered: it appears on `busRdata` one clock after the read access.

Top module: `bufWordPort`

## Requirements
- R1: After reset, `busRdata`, `irqEot` and `bufDone` are all 0.
- R2: In a write burst, opened by writing 0xC1 to select 0, each data word at select 1 stores bits 15:8 at the even byte address held by the pointer and bits 7:0 at the next odd address.
- R3: In a read burst, opened by writing 0x41 to select 0, each data read at select 1 returns the even-address byte in bits 15:8 and the odd-address byte in bits 7:0.
- R4: The byte pointer grows by two after each word that is transferred. A valid command resets it to zero.
- R5: The clock edge that transfers the word which brings the pointer to or past the byte count sets `irqEot` and `bufDone`. Before that word, neither is set. A status read at select 3 returns `irqEot` in bit 2 and `bufDone` in bit 0.
- R6: An odd byte count is rounded up to whole words. The last word still moves two bytes.
- R7: If the pointer never reaches the count, no end-of-transfer event occurs.
- R8: `irqEot` stays set until the host writes select 3 with bit 2 set. Writing 0 to bit 2 has no effect.
- R9: Once the burst has closed, data writes do not modify the buffer and data reads return 0.
- R10: A command code other than 0x41 or 0xC1 is ignored, and an open burst continues. A data read with no burst open returns 0.
- R11: A valid command clears `bufDone` but leaves `irqEot` unchanged.
- R12: An access in the opposite direction to the open burst does not advance the pointer. Such a write does not modify the buffer, and such a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busCs | input | 1 | Access strobe, one access per cycle |
| busWr | input | 1 | 1 = write access, 0 = read access |
| busSel | input | 2 | 0 command, 1 data port, 2 byte count, 3 status |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Registered read data |
| irqEot | output | 1 | Sticky end-of-transfer interrupt |
| bufDone | output | 1 | Buffer transfer complete flag |

## Verification
The bench checks the exact word on which the interrupt rises: after the second-to-last word it must still be low, and after the last word it must be high. A design that compares the pointer before it steps, or ignores odd lengths, would fire one word early or one word late. Extra writes after the close, writes during a read burst and a bogus command code are each followed by a read-back from the start of the buffer. A design that let any of them through would show corrupted bytes or a pointer that skipped a word. The bench also clears the interrupt with both a 0 and a 1 in bit 2, which catches a flag that is not sticky or that clears on any write.

// File: rtl/bufWordPort_pkg.sv
package bufWordPort_pkg;

  typedef enum logic [1:0] {
    SEL_CMD    = 2'd0,
    SEL_DATA   = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_STATUS = 2'd3
  } busSel_e;

  typedef enum logic [1:0] {
    SRC_ZERO   = 2'd0,
    SRC_RAM    = 2'd1,
    SRC_COUNT  = 2'd2,
    SRC_STATUS = 2'd3
  } rdSrc_e;

  typedef struct packed {
    logic   loadCount;
    logic   clearPtr;
    logic   writeWord;
    logic   readWord;
    logic   rdLoad;
    rdSrc_e rdSrc;
  } ctrlStrobes_t;

  localparam logic [6:0] CMD_BASE = 7'h41;

endpackage

// File: rtl/bufWordCtrl.sv
module bufWordCtrl
  import bufWordPort_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         busCs,
  input  logic         busWr,
  input  logic [1:0]   busSel,
  input  logic [15:0]  busWdata,
  input  logic         lastWord,
  output ctrlStrobes_t strobes,
  output logic         eotPulse,
  output logic         irqEot,
  output logic         bufDone
);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} burstState_e;
  burstState_e state;

  logic cmdWrite, cmdValid, dataWrite, dataRead, statusWrite, advance;

  always_comb begin
    cmdWrite    = busCs && busWr && (busSel == SEL_CMD);
    cmdValid    = cmdWrite && (busWdata[6:0] == CMD_BASE) && (busWdata[15:8] == 8'h00);
    dataWrite   = busCs && busWr && (busSel == SEL_DATA);
    dataRead    = busCs && !busWr && (busSel == SEL_DATA);
    statusWrite = busCs && busWr && (busSel == SEL_STATUS);

    strobes.loadCount = busCs && busWr && (busSel == SEL_COUNT);
    strobes.clearPtr  = cmdValid;
    strobes.writeWord = dataWrite && (state == ST_WRITE);
    strobes.readWord  = dataRead && (state == ST_READ);
    strobes.rdLoad    = busCs && !busWr;
    unique case (busSel)
      SEL_DATA:   strobes.rdSrc = strobes.readWord ? SRC_RAM : SRC_ZERO;
      SEL_COUNT:  strobes.rdSrc = SRC_COUNT;
      SEL_STATUS: strobes.rdSrc = SRC_STATUS;
      default:    strobes.rdSrc = SRC_ZERO;
    endcase

    advance  = strobes.writeWord || strobes.readWord;
    eotPulse = advance && lastWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      irqEot  <= 1'b0;
      bufDone <= 1'b0;
    end else begin
      if (cmdValid)
        state <= busWdata[7] ? ST_WRITE : ST_READ;
      else if (eotPulse)
        state <= ST_IDLE;

      if (eotPulse)
        irqEot <= 1'b1;
      else if (statusWrite && busWdata[2])
        irqEot <= 1'b0;

      if (eotPulse)
        bufDone <= 1'b1;
      else if (cmdValid)
        bufDone <= 1'b0;
    end
  end

endmodule

// File: rtl/bufWordDatapath.sv
module bufWordDatapath
  import bufWordPort_pkg::*;
#(
  parameter int DEPTH_BYTES = 64,
  localparam int ADDR_W = $clog2(DEPTH_BYTES),
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [15:0]        busWdata,
  input  logic               irqEot,
  input  logic               bufDone,
  output logic               lastWord,
  output logic [PTR_W-1:0]   ptr,
  output logic [15:0]        busRdata
);

  logic [7:0]       mem [DEPTH_BYTES];
  logic [PTR_W-1:0] byteCount;
  logic [ADDR_W-1:0] evenAddr, oddAddr;
  logic [PTR_W:0]   nextPtr;
  logic [15:0]      ramWord;

  always_comb begin
    evenAddr = {ptr[ADDR_W-1:1], 1'b0};
    oddAddr  = {ptr[ADDR_W-1:1], 1'b1};
    nextPtr  = {1'b0, ptr} + (PTR_W+1)'(2);
    lastWord = nextPtr >= {1'b0, byteCount};
    ramWord  = {mem[evenAddr], mem[oddAddr]};
  end

  always_ff @(posedge clk) begin
    if (strobes.writeWord) begin
      mem[evenAddr] <= busWdata[15:8];
      mem[oddAddr]  <= busWdata[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr       <= '0;
      byteCount <= '0;
      busRdata  <= '0;
    end else begin
      if (strobes.clearPtr)
        ptr <= '0;
      else if (strobes.writeWord || strobes.readWord)
        ptr <= nextPtr[PTR_W-1:0];

      if (strobes.loadCount)
        byteCount <= busWdata[PTR_W-1:0];

      if (strobes.rdLoad) begin
        unique case (strobes.rdSrc)
          SRC_RAM:    busRdata <= ramWord;
          SRC_COUNT:  busRdata <= 16'(byteCount);
          SRC_STATUS: busRdata <= {13'b0, irqEot, 1'b0, bufDone};
          default:    busRdata <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/bufWordPort.sv
module bufWordPort
  import bufWordPort_pkg::*;
#(
  parameter int DEPTH_BYTES = 64,
  localparam int PTR_W = $clog2(DEPTH_BYTES) + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busCs,
  input  logic        busWr,
  input  logic [1:0]  busSel,
  input  logic [15:0] busWdata,
  output logic [15:0] busRdata,
  output logic        irqEot,
  output logic        bufDone
);

  ctrlStrobes_t     strobes;
  logic             lastWord;
  logic             eotPulse;
  logic [PTR_W-1:0] ptr;

  bufWordCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .busCs(busCs), .busWr(busWr), .busSel(busSel),
    .busWdata(busWdata), .lastWord(lastWord), .strobes(strobes),
    .eotPulse(eotPulse), .irqEot(irqEot), .bufDone(bufDone)
  );

  bufWordDatapath #(.DEPTH_BYTES(DEPTH_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWdata(busWdata),
    .irqEot(irqEot), .bufDone(bufDone), .lastWord(lastWord), .ptr(ptr),
    .busRdata(busRdata)
  );

endmodule

// File: rtl/bufWordPort_checker.sv
module bufWordPort_checker #(
  parameter int PTR_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             busCs,
  input logic             busWr,
  input logic [1:0]       busSel,
  input logic [15:0]      busWdata,
  input logic [15:0]      busRdata,
  input logic             irqEot,
  input logic             bufDone,
  input logic             eotPulse,
  input logic             wordAdvance,
  input logic [PTR_W-1:0] ptr
);

  logic irqClearReq, cmdAccess, idleDataRead;
  assign irqClearReq  = busCs && busWr && (busSel == 2'd3) && busWdata[2];
  assign cmdAccess    = busCs && busWr && (busSel == 2'd0);
  assign idleDataRead = busCs && !busWr && (busSel == 2'd1) && !wordAdvance;

  assert_eot_sets_flags_R5: assert property (@(posedge clk) disable iff (!rstN)
    eotPulse |=> (irqEot && bufDone));

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqEot && !irqClearReq) |=> irqEot);

  assert_no_spurious_irq_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!irqEot && !eotPulse) |=> !irqEot);

  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    wordAdvance |=> (ptr == $past(ptr) + PTR_W'(2)));

  assert_closed_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (bufDone && !cmdAccess) |=> $stable(ptr));

  assert_idle_read_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    idleDataRead |=> (busRdata == 16'h0000));

endmodule

bind bufWordPort bufWordPort_checker #(.PTR_W(PTR_W)) u_checker (
  .clk(clk), .rstN(rstN), .busCs(busCs), .busWr(busWr), .busSel(busSel),
  .busWdata(busWdata), .busRdata(busRdata), .irqEot(irqEot), .bufDone(bufDone),
  .eotPulse(eotPulse), .wordAdvance(strobes.writeWord || strobes.readWord),
  .ptr(ptr)
);

// File: tb/bufWordPort_bench.sv
module bufWordPort_bench;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busCs = 1'b0;
  logic        busWr = 1'b0;
  logic [1:0]  busSel = 2'd0;
  logic [15:0] busWdata = 16'h0;
  logic [15:0] busRdata;
  logic        irqEot, bufDone;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [15:0] expQ[$];
  string       tagQ[$];
  logic        rdPending = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bufWordPort u_bufWordPort (
    .clk(clk), .rstN(rstN), .busCs(busCs), .busWr(busWr), .busSel(busSel),
    .busWdata(busWdata), .busRdata(busRdata), .irqEot(irqEot), .bufDone(bufDone)
  );

  // Monitor: a read issued at a posedge shows its data at the next negedge.
  always @(posedge clk) rdPending <= busCs && !busWr && rstN;

  always @(negedge clk) begin
    if (rdPending && expQ.size() > 0) begin
      logic [15:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (busRdata !== e) begin
        errors++;
        $display("FAIL %s rdata got %h exp %h", t, busRdata, e);
      end
    end
  end

  task automatic busWrite(input logic [1:0] sel, input logic [15:0] data);
    busCs = 1'b1; busWr = 1'b1; busSel = sel; busWdata = data;
    @(negedge clk);
    busCs = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] sel, input logic [15:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    busCs = 1'b1; busWr = 1'b0; busSel = sel;
    @(negedge clk);
    busCs = 1'b0;
  endtask

  task automatic checkBit(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b exp %b", tag, got, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog got timeout exp completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    checkBit(busRdata == 16'h0, 1'b1, "R1 rdata");
    checkBit(irqEot, 1'b0, "R1 irq");
    checkBit(bufDone, 1'b0, "R1 done");
    busRead(2'd3, 16'h0000, "R1 status");
    busRead(2'd1, 16'h0000, "R10 idle read");

    // Write burst, 8 bytes
    busWrite(2'd2, 16'd8);
    busWrite(2'd0, 16'h00C1);
    busWrite(2'd1, 16'h1122);
    busRead(2'd1, 16'h0000, "R12 read in write burst");
    busWrite(2'd1, 16'h3344);
    busWrite(2'd1, 16'h5566);
    checkBit(irqEot, 1'b0, "R5 no early irq");
    busWrite(2'd1, 16'h7788);
    checkBit(irqEot, 1'b1, "R5 irq at count");
    checkBit(bufDone, 1'b1, "R5 done at count");
    busWrite(2'd1, 16'hDEAD); // R9 ignored
    busRead(2'd3, 16'h0005, "R5 status");
    busWrite(2'd3, 16'h0000);
    checkBit(irqEot, 1'b1, "R8 sticky on zero write");
    busWrite(2'd3, 16'h0004);
    checkBit(irqEot, 1'b0, "R8 clear");

    // Read burst back
    busWrite(2'd0, 16'h0041);
    checkBit(bufDone, 1'b0, "R11 done cleared");
    busRead(2'd1, 16'h1122, "R3 word0");
    busRead(2'd1, 16'h3344, "R2 word1");
    busRead(2'd1, 16'h5566, "R3 word2");
    busRead(2'd1, 16'h7788, "R9 word3 not overwritten");
    checkBit(irqEot, 1'b1, "R5 read eot");
    busRead(2'd1, 16'h0000, "R9 read after eot");
    busWrite(2'd0, 16'h00C1);
    checkBit(irqEot, 1'b1, "R11 irq kept");
    busWrite(2'd3, 16'h0004);

    // Odd count 5
    busWrite(2'd2, 16'd5);
    busWrite(2'd0, 16'h00C1);
    busWrite(2'd1, 16'hA1B2);
    busWrite(2'd1, 16'hC3D4);
    checkBit(irqEot, 1'b0, "R6 not yet");
    busWrite(2'd1, 16'hE5F6);
    checkBit(irqEot, 1'b1, "R6 rounded eot");
    busWrite(2'd3, 16'h0004);

    // Partial read burst, count 8
    busWrite(2'd2, 16'd8);
    busRead(2'd2, 16'h0008, "R4 count readback");
    busWrite(2'd0, 16'h0041);
    busRead(2'd1, 16'hA1B2, "R4 restart at zero");
    busWrite(2'd1, 16'h0BAD);
    busRead(2'd1, 16'hC3D4, "R12 no advance on write");
    busWrite(2'd0, 16'h0055);
    busRead(2'd1, 16'hE5F6, "R6 last word full");
    checkBit(irqEot, 1'b0, "R7 no eot");
    checkBit(bufDone, 1'b0, "R7 no done");
    busWrite(2'd0, 16'h0041);
    busRead(2'd1, 16'hA1B2, "R10 bad cmd ignored");
    busRead(2'd1, 16'hC3D4, "R12 ram intact");
    busRead(2'd1, 16'hE5F6, "R4 word2");
    busRead(2'd1, 16'h7788, "R4 word3");
    checkBit(irqEot, 1'b1, "R5 final eot");

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule